// File: doc/BRIEF.md
# Two-Lane Streaming Bit Reversal

This block reorders a continuous stream of frames from bit-reversed index order into natural index order. Each frame holds N = 2^LOG_N samples and arrives two samples per beat, so a frame takes N/2 beats. With the default LOG_N = 5, a frame is 32 samples over 16 beats.

The work is split across two stages. Both stages are driven by one free-running beat counter, which advances only on beats where `in_valid` is high.

- **Reversal stage.** A single RAM with one entry per two lanes holds N/4 entries. It reverses the lower serial index bits of both lanes at once. Its address alternates between a straight reading and a mirrored reading of the counter's low bits, one reading per half frame.
- **Exchange stage.** An N/4-entry lane-pair delay memory and two 2:1 selectors exchange the lane bit with the top serial index bit.

Storage totals N samples. The stream may run frame after frame with no idle beats. When `in_valid` drops, everything freezes and the stream resumes on the next valid beat.

The block is intended to sit after a two-lane pipelined transform stage whose results leave in bit-reversed order. The upstream stage keeps `in_valid` high for back-to-back frames. The downstream logic consumes each beat on which `out_valid` is high. A frame's results are flushed out by the first frame of input that follows it.

Top module: `bitrev_pair_stream`

## Requirements
- R1: After reset release, `out_valid` stays low until 16 beats (N/2) have been accepted, even when `in_valid` is high during or after reset.
- R2: Input convention: on accepted beat k (0..15) of a frame, lane 0 carries sample index rev4(k) and lane 1 carries index 16 + rev4(k). Here rev4 mirrors the 4 bits of k, so bit 0 swaps with bit 3 and bit 1 swaps with bit 2.
- R3: On valid output beat k (0..15) of a frame, lane 0 presents sample index 2k and lane 1 presents sample index 2k+1 of that frame.
- R4: Once primed, `out_valid` equals `in_valid` on every cycle. Consecutive frames therefore leave with no bubble between them.
- R5: A cycle with `in_valid` low shows `out_valid` low and alters neither the order nor the content of later outputs.
- R6: The internal beat position advances by one per accepted beat only and wraps every 16 beats. Frame boundaries stay aligned across idle gaps, including gaps placed exactly between frames.
- R7: Asserting `rst_n` in the middle of a frame discards the partial frame and restarts priming. The first output after re-priming is indices 0 and 1 of the first frame sent after reset.
- R8: Sample payloads of the full DATA_W width pass unchanged. Only their position in the stream is altered.
- R9: The output pair for input beat k of frame f appears on input beat k of frame f+1, exactly 16 accepted beats later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Marks a beat carrying two input samples |
| in_lane0 | input | DATA_W | Input sample, lane 0 |
| in_lane1 | input | DATA_W | Input sample, lane 1 |
| out_valid | output | 1 | Marks a beat carrying two output samples |
| out_lane0 | output | DATA_W | Output sample, lane 0 (even index) |
| out_lane1 | output | DATA_W | Output sample, lane 1 (odd index) |

## Verification
Every output pair is due on the same clock cycle as the input beat that sits 16 accepted beats after its source beat. The outputs are read combinationally from stored state, so they are visible before the next rising edge.

The bench drives inputs one nanosecond after a rising edge and samples outputs at the following falling edge. It counts only accepted beats when working out which frame and which position are due, so idle gaps shift the expected values without any special case.

During priming and on idle beats, the expected result is a low `out_valid`. Otherwise the expected result is indices 2k and 2k+1 of the frame recorded one frame earlier, tagged with that frame's payload bits.

// File: rtl/brv_pkg.sv
package brv_pkg;

  localparam int unsigned LANES = 2;

  typedef enum logic {
    XCH_SWAP = 1'b0,
    XCH_PASS = 1'b1
  } xch_mode_e;

endpackage

// File: rtl/brv_ctrl.sv
module brv_ctrl #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [CNT_W-1:0] beat_cnt,
  output logic             primed
);

  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             primed_q, primed_d;

  always_comb begin
    cnt_d    = cnt_q;
    primed_d = primed_q;
    if (adv) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) begin
        primed_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      primed_q <= primed_d;
    end
  end

  assign beat_cnt = cnt_q;
  assign primed   = primed_q;

endmodule

// File: rtl/brv_pair_ram.sv
module brv_pair_ram #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned LANES  = 2
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [LANES-1:0][DATA_W-1:0] wdata,
  output logic [LANES-1:0][DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en) begin
        store[addr] <= wdata[ln];
      end
    end

    assign rdata[ln] = store[addr];
  end

endmodule

// File: rtl/brv_reverse_stage.sv
module brv_reverse_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 4
) (
  input  logic                                  clk,
  input  logic                                  adv,
  input  logic [CNT_W-1:0]                      beat_cnt,
  input  logic [brv_pkg::LANES-1:0][DATA_W-1:0] din,
  output logic [brv_pkg::LANES-1:0][DATA_W-1:0] dout
);

  localparam int unsigned ADDR_W = CNT_W - 1;

  logic [ADDR_W-1:0] low_bits;
  logic [ADDR_W-1:0] low_mirror;
  logic [ADDR_W-1:0] ram_addr;
  logic              mirror_half;

  assign low_bits    = beat_cnt[ADDR_W-1:0];
  assign mirror_half = beat_cnt[CNT_W-1];

  for (genvar b = 0; b < ADDR_W; b++) begin : g_mirror
    assign low_mirror[b] = low_bits[ADDR_W-1-b];
  end

  always_comb begin
    ram_addr = low_bits;
    if (mirror_half) begin
      ram_addr = low_mirror;
    end
  end

  brv_pair_ram #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .LANES (brv_pkg::LANES)
  ) u_rev_ram (
    .clk  (clk),
    .wr_en(adv),
    .addr (ram_addr),
    .wdata(din),
    .rdata(dout)
  );

endmodule

// File: rtl/brv_exchange_stage.sv
module brv_exchange_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                                  clk,
  input  logic                                  adv,
  input  logic [ADDR_W-1:0]                     addr,
  input  brv_pkg::xch_mode_e                    mode,
  input  logic [brv_pkg::LANES-1:0][DATA_W-1:0] din,
  output logic [brv_pkg::LANES-1:0][DATA_W-1:0] dout
);

  import brv_pkg::*;

  logic [LANES-1:0][DATA_W-1:0] buf_wr;
  logic [LANES-1:0][DATA_W-1:0] buf_rd;
  logic [DATA_W-1:0]            held_lane1;
  logic [DATA_W-1:0]            upper_sel;
  logic [DATA_W-1:0]            lower_sel;

  // entry 0 delays lane 1 ahead of the exchange, entry 1 delays the upper result after it
  assign held_lane1 = buf_rd[0];

  always_comb begin
    if (mode == XCH_PASS) begin
      upper_sel = din[0];
      lower_sel = held_lane1;
    end else begin
      upper_sel = held_lane1;
      lower_sel = din[0];
    end
  end

  assign buf_wr[0] = din[1];
  assign buf_wr[1] = upper_sel;

  brv_pair_ram #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .LANES (LANES)
  ) u_xch_ram (
    .clk  (clk),
    .wr_en(adv),
    .addr (addr),
    .wdata(buf_wr),
    .rdata(buf_rd)
  );

  assign dout[0] = buf_rd[1];
  assign dout[1] = lower_sel;

endmodule

// File: rtl/bitrev_pair_stream.sv
module bitrev_pair_stream #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LOG_N  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_lane0,
  input  logic [DATA_W-1:0] in_lane1,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_lane0,
  output logic [DATA_W-1:0] out_lane1
);

  import brv_pkg::*;

  localparam int unsigned CNT_W  = LOG_N - 1;
  localparam int unsigned ADDR_W = LOG_N - 2;

  logic                         rst_meta_n;
  logic                         rst_sync_n;
  logic [CNT_W-1:0]             beat_cnt;
  logic                         primed;
  logic [LANES-1:0][DATA_W-1:0] lanes_in;
  logic [LANES-1:0][DATA_W-1:0] lanes_mid;
  logic [LANES-1:0][DATA_W-1:0] lanes_out;
  xch_mode_e                    xch_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  brv_ctrl #(
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .adv     (in_valid),
    .beat_cnt(beat_cnt),
    .primed  (primed)
  );

  assign lanes_in[0] = in_lane0;
  assign lanes_in[1] = in_lane1;

  brv_reverse_stage #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_reverse (
    .clk     (clk),
    .adv     (in_valid),
    .beat_cnt(beat_cnt),
    .din     (lanes_in),
    .dout    (lanes_mid)
  );

  assign xch_mode = beat_cnt[CNT_W-1] ? XCH_PASS : XCH_SWAP;

  brv_exchange_stage #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_exchange (
    .clk (clk),
    .adv (in_valid),
    .addr(beat_cnt[ADDR_W-1:0]),
    .mode(xch_mode),
    .din (lanes_mid),
    .dout(lanes_out)
  );

  assign out_valid = in_valid & primed;
  assign out_lane0 = lanes_out[0];
  assign out_lane1 = lanes_out[1];

endmodule

// File: rtl/brv_checker.sv
module brv_checker #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [CNT_W-1:0] beat_cnt,
  input logic             primed
);

  assert_cnt_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> beat_cnt == CNT_W'($past(beat_cnt) + 1'b1));

  assert_cnt_holds_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(beat_cnt));

  assert_no_out_before_primed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !out_valid);

  assert_out_needs_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);

  assert_primed_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed);

  assert_primed_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(primed) |-> (beat_cnt == '0) && ($past(beat_cnt) == {CNT_W{1'b1}}));

endmodule

bind bitrev_pair_stream brv_checker #(
  .CNT_W(LOG_N - 1)
) u_brv_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .beat_cnt (beat_cnt),
  .primed   (primed)
);

// File: tb/tb_bitrev_pair_stream.sv
`timescale 1ns/1ps
module tb_bitrev_pair_stream;

  localparam int DW = 16;
  localparam int FR = 16;
  localparam int NF = 7;
  // frame payload tag, beat index before which a gap opens (16 = none), gap length
  localparam int TAG_TBL [NF] = '{3, 5, 0, 7, 1, 6, 2};
  localparam int GAP_AT  [NF] = '{16, 16, 5, 16, 0, 16, 15};
  localparam int GAP_LEN [NF] = '{0, 0, 3, 0, 2, 0, 1};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_lane0, in_lane1;
  logic          out_valid;
  logic [DW-1:0] out_lane0, out_lane1;

  int    checks = 0;
  int    errors = 0;
  int    acc = 0;
  int    tag_hist [64];
  string prime_req = "R1";
  bit    finished = 1'b0;

  always #4 clk = ~clk;

  bitrev_pair_stream #(.DATA_W(DW), .LOG_N(5)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_lane0(in_lane0), .in_lane1(in_lane1),
    .out_valid(out_valid), .out_lane0(out_lane0), .out_lane1(out_lane1)
  );

  function automatic int rev4(int k);
    return ((k & 1) << 3) | ((k & 2) << 1) | ((k & 4) >> 1) | ((k & 8) >> 3);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic beat(bit v, int tag);
    int k;
    int e;
    @(posedge clk); #1;
    in_valid = v;
    if (v) begin
      k = acc % FR;
      tag_hist[acc / FR] = tag;
      in_lane0 = DW'(tag * 32 + rev4(k));
      in_lane1 = DW'(tag * 32 + 16 + rev4(k));
    end else begin
      in_lane0 = '0;
      in_lane1 = '0;
    end
    @(negedge clk);
    if (!v) begin
      check("R5", "out_valid on idle beat", int'(out_valid), 0);
    end else if (acc < FR) begin
      check(prime_req, "out_valid while priming", int'(out_valid), 0);
    end else begin
      check("R4", "out_valid once primed", int'(out_valid), 1);
      e = tag_hist[(acc - FR) / FR] * 32 + 2 * ((acc - FR) % FR);
      check("R2/R3/R6/R8/R9", "lane0", int'(out_lane0), e);
      check("R2/R3/R6/R8/R9", "lane1", int'(out_lane1), e + 1);
    end
    if (v) acc++;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    check("R1", "out_valid during reset", int'(out_valid), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    in_valid = 1'b0;
    acc = 0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_lane0 = '0;
    in_lane1 = '0;
    do_reset();

    // table-driven stream, gaps inside and between frames
    for (int f = 0; f < NF; f++) begin
      for (int k = 0; k < FR; k++) begin
        if (k == GAP_AT[f]) begin
          for (int g = 0; g < GAP_LEN[f]; g++) beat(1'b0, 0);
        end
        beat(1'b1, TAG_TBL[f]);
      end
    end
    // flush frame brings out the last table frame
    for (int k = 0; k < FR; k++) beat(1'b1, 4);

    // R7: reset part-way through a frame
    for (int k = 0; k < 5; k++) beat(1'b1, 2);
    do_reset();
    prime_req = "R7";
    for (int k = 0; k < FR; k++) beat(1'b1, 6);
    for (int k = 0; k < FR; k++) beat(1'b1, 1);

    summary();
  end

endmodule